// File: doc/BRIEF.md
# Super I/O Configuration Port

This block is the configuration front end of a multi-function peripheral controller that sits on a simple ISA-style I/O bus. Software reaches it through two adjacent I/O addresses. The lower one is an index port that selects a configuration register. The upper one is a data port that reads or writes the selected register. To guard against stray writes, the register file accepts data-port writes only after an unlock key has gone through the index port. A second key closes it again. Reads are never blocked.

Six 8-bit configuration registers are held here and driven straight out to the chip's address-decode logic: function enables, base-address choices, power-down controls, test mode, miscellaneous settings and extended parallel-port settings. The block also decodes the two relocatable serial-port base addresses from the miscellaneous register. It raises a one-cycle pulse whenever the function or address register is written, so the decoder knows to re-evaluate its chip selects. Setting the port-disable bit in the power-down register takes the block off the bus until the next reset.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the function register reads 0x03, the other five registers read 0x00, the index is 0x00, configuration is locked, `remap_pulse` is low, and the serial bases are 0x3E8 and 0x2E8.
- R2: A write of 0x33 to the index port (0x398) unlocks configuration, and a write of 0xCC locks it. In both cases the written value also becomes the index.
- R3: While locked, a write to the data port (0x399) changes no register.
- R4: A read strobe on either port returns the register selected by the current index, whether locked or unlocked, on the same cycle (combinational).
- R5: While unlocked, a data-port write stores the byte in the selected register. The registers sit at index 0xA0 (function), 0xA1 (address), 0xA2 (power-down), 0xA3 (test), 0xA4 (miscellaneous) and 0xA5 (extended parallel), and each is driven on its own output from the clock edge that stores it.
- R6: An index outside 0xA0..0xA5 reads as 0x00, and a data write at such an index changes no exported register.
- R7: Miscellaneous bits 7:6 select the third/fourth serial bases: 00 gives 0x3E8/0x2E8, 01 gives 0x338/0x238, 10 gives 0x2E8/0x2E0, and 11 gives 0x220/0x228.
- R8: Once power-down bit 6 is set, both ports ignore writes (index, lock state and registers hold) and reads return 0x00 until reset.
- R9: An accepted data write to index 0xA0 or 0xA1 makes `remap_pulse` high for exactly the following cycle. Writes to other indices do not raise it.
- R10: `io_rdata` is 0x00 when no read strobe is present or the address is neither port, and bus writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | I/O address |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | Single-cycle write strobe |
| io_rd | input | 1 | Read strobe |
| io_rdata | output | 8 | Read data, combinational |
| func_sel | output | 8 | Function-enable register (index 0xA0) |
| addr_sel | output | 8 | Base-address select register (index 0xA1) |
| pwr_down | output | 8 | Power-down register (index 0xA2) |
| test_mode | output | 8 | Test-mode register (index 0xA3) |
| misc_cfg | output | 8 | Miscellaneous register (index 0xA4) |
| ext_par | output | 8 | Extended parallel-port register (index 0xA5) |
| ser3_base | output | 16 | Decoded third serial base address |
| ser4_base | output | 16 | Decoded fourth serial base address |
| remap_pulse | output | 1 | One-cycle pulse after a function or address register write |

## Verification
The register file is exercised with data writes in three states: locked, unlocked, and locked again after the second key. This separates a gate that follows the key values from one that latches any index write. The same data bytes are aimed at in-window indices, at the key index 0x33, and at a neighbouring address, which shows whether the window decode and the port decode are exact. All four settings of the miscellaneous select field are walked to catch a swapped base pair. Writes to the function and address registers are interleaved with writes to the other four, and the pulse is checked both on the cycle after each write and on the cycle after that. The run ends by setting the port-disable bit and confirming that later keys, writes and reads have no effect.

// File: rtl/sio_cfg_port.sv
module sio_cfg_port #(
  parameter int              AW        = 16,
  parameter int              DW        = 8,
  parameter logic [AW-1:0]   IDX_PORT  = 16'h0398,
  parameter logic [AW-1:0]   DAT_PORT  = 16'h0399,
  parameter logic [DW-1:0]   OPEN_KEY  = 8'h33,
  parameter logic [DW-1:0]   SHUT_KEY  = 8'hCC,
  parameter logic [DW-1:0]   REG_BASE  = 8'hA0,
  parameter logic [DW-1:0]   FSEL_INIT = 8'h03,
  parameter int              QUIET_BIT = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] io_addr,
  input  logic [DW-1:0] io_wdata,
  input  logic          io_wr,
  input  logic          io_rd,
  output logic [DW-1:0] io_rdata,
  output logic [DW-1:0] func_sel,
  output logic [DW-1:0] addr_sel,
  output logic [DW-1:0] pwr_down,
  output logic [DW-1:0] test_mode,
  output logic [DW-1:0] misc_cfg,
  output logic [DW-1:0] ext_par,
  output logic [AW-1:0] ser3_base,
  output logic [AW-1:0] ser4_base,
  output logic          remap_pulse
);
  localparam int NREG = 6;
  localparam int SW   = $clog2(NREG);

  logic [DW-1:0] cfg [NREG];
  logic [DW-1:0] idx;
  logic          unlocked;
  logic          remap_q;

  logic          quiet, idx_hit, dat_hit, idx_wr, dat_wr, in_win;
  logic [DW-1:0] off, cur;
  logic [SW-1:0] slot;

  assign quiet   = cfg[2][QUIET_BIT];
  assign idx_hit = (io_addr == IDX_PORT);
  assign dat_hit = (io_addr == DAT_PORT);
  assign idx_wr  = io_wr && idx_hit && !quiet;
  assign dat_wr  = io_wr && dat_hit && !quiet && unlocked;
  assign off     = idx - REG_BASE;
  assign slot    = off[SW-1:0];
  assign in_win  = (idx >= REG_BASE) && ({1'b0, idx} < ({1'b0, REG_BASE} + (DW+1)'(NREG)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx      <= '0;
      unlocked <= 1'b0;
    end else if (idx_wr) begin
      idx <= io_wdata;
      if (io_wdata == OPEN_KEY)      unlocked <= 1'b1;
      else if (io_wdata == SHUT_KEY) unlocked <= 1'b0;
    end
  end

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)
        cfg[i] <= (i == 0) ? FSEL_INIT : '0;
      else if (dat_wr && in_win && slot == SW'(i))
        cfg[i] <= io_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) remap_q <= 1'b0;
    else        remap_q <= dat_wr && in_win && (slot == SW'(0) || slot == SW'(1));
  end

  always_comb begin
    cur = '0;
    for (int i = 0; i < NREG; i++)
      if (in_win && slot == SW'(i)) cur = cfg[i];
  end

  assign io_rdata = (io_rd && (idx_hit || dat_hit) && !quiet) ? cur : '0;

  assign func_sel    = cfg[0];
  assign addr_sel    = cfg[1];
  assign pwr_down    = cfg[2];
  assign test_mode   = cfg[3];
  assign misc_cfg    = cfg[4];
  assign ext_par     = cfg[5];
  assign remap_pulse = remap_q;

  always_comb begin
    case (cfg[4][7:6])
      2'b00:   begin ser3_base = AW'('h3E8); ser4_base = AW'('h2E8); end
      2'b01:   begin ser3_base = AW'('h338); ser4_base = AW'('h238); end
      2'b10:   begin ser3_base = AW'('h2E8); ser4_base = AW'('h2E0); end
      default: begin ser3_base = AW'('h220); ser4_base = AW'('h228); end
    endcase
  end

  a_r2_open_key: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && idx_hit && !quiet && io_wdata == OPEN_KEY) |=> unlocked);
  a_r2_shut_key: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && idx_hit && !quiet && io_wdata == SHUT_KEY) |=> !unlocked);
  a_r3_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> ($stable(func_sel) && $stable(addr_sel) && $stable(pwr_down) &&
                   $stable(test_mode) && $stable(misc_cfg) && $stable(ext_par)));
  a_r8_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |=> (quiet && $stable(idx) && $stable(unlocked) && $stable(func_sel)));
  a_r8_quiet_read: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |-> (io_rdata == '0));
  a_r9_pulse_src: assert property (@(posedge clk) disable iff (!rst_n)
    remap_pulse |-> $past(io_wr && dat_hit && unlocked));
  a_r10_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |-> (io_rdata == '0));
endmodule

// File: tb/tb_sio_cfg_port.sv
`timescale 1ns/100ps
module tb_sio_cfg_port;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] io_addr = 0;
  logic [7:0]  io_wdata = 0;
  logic        io_wr = 0, io_rd = 0;
  logic [7:0]  io_rdata, func_sel, addr_sel, pwr_down, test_mode, misc_cfg, ext_par;
  logic [15:0] ser3_base, ser4_base;
  logic        remap_pulse;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  typedef struct { logic [7:0] exp; string tag; } item_t;
  item_t sb[$];
  event  rd_ev;

  always #2.5 clk = ~clk;

  sio_cfg_port dut (.clk, .rst_n, .io_addr, .io_wdata, .io_wr, .io_rd, .io_rdata,
    .func_sel, .addr_sel, .pwr_down, .test_mode, .misc_cfg, .ext_par,
    .ser3_base, .ser4_base, .remap_pulse);

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  always @(rd_ev) begin
    item_t it;
    it = sb.pop_front();
    chk(it.tag, {8'h00, io_rdata}, {8'h00, it.exp});
  end

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1;
    @(negedge clk); io_wr = 0;
  endtask

  task automatic rd(input logic [15:0] a, input bit strobe, input logic [7:0] exp, input string tag);
    item_t it;
    @(negedge clk); io_addr = a; io_rd = strobe;
    #1;
    it.exp = exp; it.tag = tag;
    sb.push_back(it);
    ->rd_ev;
    #0.5;
    io_rd = 0;
  endtask

  task automatic setreg(input logic [7:0] ix, input logic [7:0] d);
    wr(16'h398, ix);
    wr(16'h399, d);
  endtask

  initial begin
    #200000;
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 func", func_sel, 8'h03);
    chk("R1 addr", addr_sel, 0);
    chk("R1 pd", pwr_down, 0);
    chk("R1 misc", misc_cfg, 0);
    chk("R1 ser3", ser3_base, 16'h3E8);
    chk("R1 ser4", ser4_base, 16'h2E8);
    chk("R1 pulse", remap_pulse, 0);
    rd(16'h398, 1, 8'h00, "R1 read idx0");
    // R3 locked write dropped, R4 locked read
    setreg(8'hA0, 8'h55);
    chk("R3 func locked", func_sel, 8'h03);
    chk("R3 no pulse", remap_pulse, 0);
    rd(16'h399, 1, 8'h03, "R4 locked read A0");
    // R2 unlock, key latched as index, R6 out of window
    wr(16'h398, 8'h33);
    rd(16'h399, 1, 8'h00, "R6 read idx33");
    wr(16'h399, 8'h77);
    chk("R6 func untouched", func_sel, 8'h03);
    chk("R6 ext untouched", ext_par, 0);
    // R5 / R9
    setreg(8'hA0, 8'h5A);
    chk("R5 func", func_sel, 8'h5A);
    chk("R9 pulse A0", remap_pulse, 1);
    @(negedge clk);
    chk("R9 pulse ends", remap_pulse, 0);
    rd(16'h398, 1, 8'h5A, "R4 read via idx port");
    setreg(8'hA1, 8'hC3);
    chk("R5 addr", addr_sel, 8'hC3);
    chk("R9 pulse A1", remap_pulse, 1);
    setreg(8'hA2, 8'h15);
    chk("R5 pd", pwr_down, 8'h15);
    chk("R9 no pulse A2", remap_pulse, 0);
    setreg(8'hA3, 8'h81);
    chk("R5 test", test_mode, 8'h81);
    setreg(8'hA5, 8'h3C);
    chk("R5 ext", ext_par, 8'h3C);
    chk("R9 no pulse A5", remap_pulse, 0);
    rd(16'h399, 1, 8'h3C, "R5 readback A5");
    // R7 serial bases
    setreg(8'hA4, 8'h40);
    chk("R7 01 ser3", ser3_base, 16'h338);
    chk("R7 01 ser4", ser4_base, 16'h238);
    chk("R9 no pulse A4", remap_pulse, 0);
    wr(16'h399, 8'h80);
    chk("R7 10 ser3", ser3_base, 16'h2E8);
    chk("R7 10 ser4", ser4_base, 16'h2E0);
    wr(16'h399, 8'hC0);
    chk("R7 11 ser3", ser3_base, 16'h220);
    chk("R7 11 ser4", ser4_base, 16'h228);
    wr(16'h399, 8'h00);
    chk("R7 00 ser3", ser3_base, 16'h3E8);
    // R2 relock
    wr(16'h398, 8'hCC);
    setreg(8'hA1, 8'h00);
    chk("R2 relocked addr", addr_sel, 8'hC3);
    rd(16'h399, 1, 8'hC3, "R4 read after relock");
    // R10 bus decode
    rd(16'h399, 0, 8'h00, "R10 no strobe");
    rd(16'h39A, 1, 8'h00, "R10 other addr");
    wr(16'h39A, 8'h33);
    wr(16'h399, 8'h11);
    chk("R10 foreign key ignored", addr_sel, 8'hC3);
    // R8 port disable
    wr(16'h398, 8'h33);
    setreg(8'hA2, 8'h40);
    chk("R8 pd set", pwr_down, 8'h40);
    rd(16'h399, 1, 8'h00, "R8 read quiet");
    setreg(8'hA0, 8'hFF);
    chk("R8 func held", func_sel, 8'h5A);
    chk("R8 pd held", pwr_down, 8'h40);
    repeat (2) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule